// File: doc/BRIEF.md
# Comparator Output Conditioner

This block is the digital stage behind an analog comparator. It takes the comparator's raw decision bit plus two optional strobes: an external sample request and a window gate. All three arrive asynchronously, so the block synchronizes them first. It then produces a clean conditioned level that downstream logic can trust. Everything runs on one bus clock.

A mode select sets how much conditioning is applied. The options are:
- direct following of the comparator;
- capture on a sample clock;
- capture plus a glitch filter that needs several consecutive agreeing samples;
- gating by the window input, which holds the last value while the window is closed;
- gating followed by filtering.

The sample clock comes either from rising edges of the external sample input or from a built-in prescaler on the bus clock.

The conditioned level drives sticky rising-edge and falling-edge flags. Each flag is cleared by writing a one to its clear bit. The flags raise either an interrupt or a DMA request. A gated pin output can carry either the conditioned level or the unconditioned, synchronized comparator value.

Top module: `cmp_condition`

## Requirements
- R1: While `rst` is high and directly after it, `cond_out`, `pin_out`, `rise_flag`, `fall_flag`, `irq` and `dma_req` are all 0.
- R2: With `cfg_mode` = 0 (continuous), `cond_out` follows `raw_in` XOR `cfg_invert`. A change applied before clock edge k shows on `cond_out` after edge k+2 and not earlier.
- R3: `cfg_invert` = 1 flips the comparator polarity ahead of every conditioning stage, so a steady `raw_in` of 1 settles to `cond_out` = 0.
- R4: With `cfg_mode` = 1 (sampled), `cond_out` updates only on sample strobes. A strobe is either a rising edge of the synchronized `samp_in` (`cfg_ext_samp` = 1) or one bus cycle in every `cfg_filt_per` cycles (`cfg_ext_samp` = 0; a period of 0 counts as 1). Without strobes, `cond_out` holds.
- R5: With `cfg_mode` = 2 (sampled and filtered), `cond_out` takes a new value only after `cfg_filt_cnt` consecutive strobed samples all differ from it (a count of 0 counts as 1). A disagreeing run that is shorter than this leaves the output unchanged. With period 4 and count 2, a change is visible no sooner than 7 and no later than 10 edges after the input moves.
- R6: With `cfg_mode` = 3 (windowed), `cond_out` loads the comparator value while the synchronized `win_in` is high. While `win_in` is low it keeps its last value.
- R7: With `cfg_mode` = 4 (window then filter), a register that loads only while the window is high feeds the R5 filter, which is clocked by the internal prescaler. A closed window therefore freezes the output.
- R8: `pin_out` is 0 whenever `cfg_pin_en` is 0. Otherwise, one edge later, it carries `cond_out` (`cfg_pin_sel` = 0) or the synchronized, polarity-adjusted comparator value (`cfg_pin_sel` = 1).
- R9: `rise_flag` (`fall_flag`) is set on the edge after `cond_out` goes 0→1 (1→0). It stays set until a cycle with `flag_clr[0]` (`flag_clr[1]`) high. A new edge takes priority over a clear in the same cycle.
- R10: The request `(rise_flag & cfg_rise_ie) | (fall_flag & cfg_fall_ie)` appears on `irq` when `cfg_dma_en` = 0 and on `dma_req` when `cfg_dma_en` = 1, never on both.
- R11: `cfg_mode` codes 5, 6 and 7 behave exactly as continuous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 1 | Asynchronous comparator decision |
| samp_in | input | 1 | Asynchronous external sample request |
| win_in | input | 1 | Asynchronous window gate |
| cfg_mode | input | 3 | 0 continuous, 1 sampled, 2 sampled+filter, 3 windowed, 4 window+filter, others continuous |
| cfg_invert | input | 1 | Invert comparator polarity |
| cfg_ext_samp | input | 1 | Sampled modes: use external sample edges instead of prescaler |
| cfg_filt_per | input | PER_W (8) | Prescaler period in bus cycles |
| cfg_filt_cnt | input | CNT_W (3) | Consecutive samples needed to change the output |
| cfg_pin_sel | input | 1 | Pin carries unconditioned value when 1 |
| cfg_pin_en | input | 1 | Enables the pin output |
| cfg_rise_ie | input | 1 | Rising-flag request enable |
| cfg_fall_ie | input | 1 | Falling-flag request enable |
| cfg_dma_en | input | 1 | Route the request to DMA instead of interrupt |
| flag_clr | input | 2 | Write-one-to-clear pulses: bit 0 rising flag, bit 1 falling flag |
| cond_out | output | 1 | Conditioned comparator level |
| pin_out | output | 1 | Gated pin output |
| rise_flag | output | 1 | Sticky rising-edge flag |
| fall_flag | output | 1 | Sticky falling-edge flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The window-hold and external-sample-hold properties look three cycles into the past. They assume that configuration only changes between cycles and that a low level seen on an asynchronous input reaches the synchronizer output two edges later. The stimulus therefore drives every input on the falling clock edge and holds the configuration steady for several cycles around each measured transition. It also keeps each strobe level steady for at least one full cycle, so no sample edge is lost.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;
  typedef enum logic [2:0] {
    MODE_CONT  = 3'd0,
    MODE_SAMP  = 3'd1,
    MODE_SFILT = 3'd2,
    MODE_WIN   = 3'd3,
    MODE_WFILT = 3'd4
  } cmpc_mode_e;
endpackage

// File: rtl/cmpc_sync.sv
module cmpc_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= async_in[i];
        s2 <= s1;
      end
    end
    assign sync_out[i] = s2;
  end
endmodule

// File: rtl/cmpc_strobe.sv
module cmpc_strobe #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_ext,
  input  logic [PER_W-1:0] period,
  input  logic             ext_lvl,
  output logic             strobe
);
  logic [PER_W-1:0] cnt;
  logic [PER_W-1:0] last;
  logic             ext_d;
  logic             wrap;

  assign last = (period == '0) ? '0 : period - 1'b1;
  assign wrap = (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ext_d <= 1'b0;
    end else begin
      ext_d <= ext_lvl;
      cnt   <= wrap ? '0 : cnt + 1'b1;
    end
  end

  assign strobe = use_ext ? (ext_lvl & ~ext_d) : wrap;
endmodule

// File: rtl/cmpc_filter.sv
module cmpc_filter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             direct,
  input  logic             load,
  input  logic             strobe,
  input  logic             sample,
  input  logic [CNT_W-1:0] need,
  output logic             level
);
  logic [CNT_W-1:0] run;
  logic [CNT_W:0]   run_nx;
  logic [CNT_W:0]   need_eff;

  assign need_eff = (need == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, need};
  assign run_nx   = {1'b0, run} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      run   <= '0;
    end else if (direct) begin
      run <= '0;
      if (load) level <= sample;
    end else if (strobe) begin
      if (sample == level) begin
        run <= '0;
      end else if (run_nx >= need_eff) begin
        level <= sample;
        run   <= '0;
      end else begin
        run <= run_nx[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cmp_condition.sv
module cmp_condition
  import cmpc_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             raw_in,
  input  logic             samp_in,
  input  logic             win_in,
  input  logic [2:0]       cfg_mode,
  input  logic             cfg_invert,
  input  logic             cfg_ext_samp,
  input  logic [PER_W-1:0] cfg_filt_per,
  input  logic [CNT_W-1:0] cfg_filt_cnt,
  input  logic             cfg_pin_sel,
  input  logic             cfg_pin_en,
  input  logic             cfg_rise_ie,
  input  logic             cfg_fall_ie,
  input  logic             cfg_dma_en,
  input  logic [1:0]       flag_clr,
  output logic             cond_out,
  output logic             pin_out,
  output logic             rise_flag,
  output logic             fall_flag,
  output logic             irq,
  output logic             dma_req
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] sync_v;
  logic raw_s, samp_s, win_s;
  logic cmp_v, win_hold;
  logic is_samp, is_win, is_wfilt, direct, load, strobe, sample;
  logic [CNT_W-1:0] need;
  logic cond_prev, rise_det, fall_det, req;
  cmpc_mode_e mode;

  cmpc_sync #(.W(NSYNC)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({win_in, samp_in, raw_in}),
    .sync_out(sync_v)
  );
  assign {win_s, samp_s, raw_s} = sync_v;

  assign cmp_v = raw_s ^ cfg_invert;
  assign mode  = cmpc_mode_e'(cfg_mode);

  always_comb begin
    is_samp  = 1'b0;
    is_win   = 1'b0;
    is_wfilt = 1'b0;
    need     = cfg_filt_cnt;
    case (mode)
      MODE_SAMP:  begin is_samp = 1'b1; need = {{(CNT_W-1){1'b0}}, 1'b1}; end
      MODE_SFILT: is_samp  = 1'b1;
      MODE_WIN:   is_win   = 1'b1;
      MODE_WFILT: is_wfilt = 1'b1;
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        win_hold <= 1'b0;
    else if (win_s) win_hold <= cmp_v;
  end

  assign direct = ~(is_samp | is_wfilt);
  assign load   = is_win ? win_s : 1'b1;
  assign sample = is_wfilt ? win_hold : cmp_v;

  cmpc_strobe #(.PER_W(PER_W)) u_strobe (
    .clk(clk), .rst(rst),
    .use_ext(is_samp & cfg_ext_samp),
    .period(cfg_filt_per),
    .ext_lvl(samp_s),
    .strobe(strobe)
  );

  cmpc_filter #(.CNT_W(CNT_W)) u_filter (
    .clk(clk), .rst(rst),
    .direct(direct), .load(load), .strobe(strobe),
    .sample(sample), .need(need),
    .level(cond_out)
  );

  assign rise_det = cond_out & ~cond_prev;
  assign fall_det = ~cond_out & cond_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_prev <= 1'b0;
      rise_flag <= 1'b0;
      fall_flag <= 1'b0;
      pin_out   <= 1'b0;
    end else begin
      cond_prev <= cond_out;
      rise_flag <= rise_det | (rise_flag & ~flag_clr[0]);
      fall_flag <= fall_det | (fall_flag & ~flag_clr[1]);
      pin_out   <= cfg_pin_en & (cfg_pin_sel ? cmp_v : cond_out);
    end
  end

  assign req     = (rise_flag & cfg_rise_ie) | (fall_flag & cfg_fall_ie);
  assign irq     = req & ~cfg_dma_en;
  assign dma_req = req & cfg_dma_en;
endmodule

// File: rtl/cmp_condition_chk.sv
module cmp_condition_chk (
  input logic       clk,
  input logic       rst,
  input logic       samp_in,
  input logic       win_in,
  input logic [2:0] cfg_mode,
  input logic       cfg_ext_samp,
  input logic       cfg_pin_en,
  input logic [1:0] flag_clr,
  input logic       cond_out,
  input logic       pin_out,
  input logic       rise_flag,
  input logic       irq,
  input logic       dma_req
);
  AST_RISE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(cond_out) |=> rise_flag); // R9

  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    (flag_clr[0] && !$rose(cond_out)) |=> !rise_flag); // R9

  AST_PIN_GATED: assert property (@(posedge clk) disable iff (rst)
    !cfg_pin_en |=> !pin_out); // R8

  AST_WINDOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_mode) == 3'd3 && !$past(win_in, 3)) |-> $stable(cond_out)); // R6

  AST_EXT_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_mode) == 3'd1 && $past(cfg_ext_samp) && !$past(samp_in, 3))
      |-> $stable(cond_out)); // R4

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    !(irq && dma_req)); // R10
endmodule

bind cmp_condition cmp_condition_chk u_chk (
  .clk(clk), .rst(rst), .samp_in(samp_in), .win_in(win_in),
  .cfg_mode(cfg_mode), .cfg_ext_samp(cfg_ext_samp), .cfg_pin_en(cfg_pin_en),
  .flag_clr(flag_clr), .cond_out(cond_out), .pin_out(pin_out),
  .rise_flag(rise_flag), .irq(irq), .dma_req(dma_req)
);

// File: tb/cmp_condition_bench.sv
module cmp_condition_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic raw_in = 1'b0, samp_in = 1'b0, win_in = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic cfg_invert = 1'b0, cfg_ext_samp = 1'b0;
  logic [7:0] cfg_filt_per = 8'd0;
  logic [2:0] cfg_filt_cnt = 3'd0;
  logic cfg_pin_sel = 1'b0, cfg_pin_en = 1'b0;
  logic cfg_rise_ie = 1'b0, cfg_fall_ie = 1'b0, cfg_dma_en = 1'b0;
  logic [1:0] flag_clr = 2'b00;
  logic cond_out, pin_out, rise_flag, fall_flag, irq, dma_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cmp_condition u_cmp_condition (
    .clk(clk), .rst(rst), .raw_in(raw_in), .samp_in(samp_in), .win_in(win_in),
    .cfg_mode(cfg_mode), .cfg_invert(cfg_invert), .cfg_ext_samp(cfg_ext_samp),
    .cfg_filt_per(cfg_filt_per), .cfg_filt_cnt(cfg_filt_cnt),
    .cfg_pin_sel(cfg_pin_sel), .cfg_pin_en(cfg_pin_en),
    .cfg_rise_ie(cfg_rise_ie), .cfg_fall_ie(cfg_fall_ie), .cfg_dma_en(cfg_dma_en),
    .flag_clr(flag_clr), .cond_out(cond_out), .pin_out(pin_out),
    .rise_flag(rise_flag), .fall_flag(fall_flag), .irq(irq), .dma_req(dma_req)
  );

  // {mode[2:0], invert, window, raw, expected cond, spare}
  localparam logic [7:0] VEC [0:9] = '{
    8'b000_0_0_1_1_0, 8'b000_1_0_1_0_0, 8'b001_0_0_1_1_0, 8'b010_0_0_0_0_0,
    8'b011_0_1_1_1_0, 8'b011_0_0_0_1_0, 8'b100_0_1_0_0_0, 8'b100_0_0_1_0_0,
    8'b111_0_0_1_1_0, 8'b101_1_0_1_0_0
  };

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // wait n rising edges, then sample a quarter period later
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    string tag;
    raw_in = 1'b1;
    edges(3);
    check(cond_out, 1'b0, "R1 cond in reset");
    at_neg(); rst = 1'b0;
    edges(1);
    check(cond_out, 1'b0, "R1 cond after reset");
    check(rise_flag | fall_flag, 1'b0, "R1 flags");
    check(pin_out | irq | dma_req, 1'b0, "R1 pin/irq/dma");

    // vector table walk
    cfg_filt_per = 8'd2; cfg_filt_cnt = 3'd3;
    for (int i = 0; i < 10; i++) begin
      at_neg();
      cfg_mode = VEC[i][7:5]; cfg_invert = VEC[i][4];
      win_in = VEC[i][3]; raw_in = VEC[i][2];
      edges(40);
      case (VEC[i][7:5])
        3'd0: tag = VEC[i][4] ? "R3 invert" : "R2 continuous";
        3'd1: tag = "R4 sampled";
        3'd2: tag = "R5 filtered";
        3'd3: tag = "R6 windowed";
        3'd4: tag = "R7 window+filter";
        default: tag = VEC[i][4] ? "R11 spare code inverted R3" : "R11 spare code";
      endcase
      check(cond_out, VEC[i][1], tag);
    end

    // R2 exact latency, R9/R8 follow-through
    at_neg(); cfg_mode = 3'd0; cfg_invert = 1'b0; raw_in = 1'b0; win_in = 1'b0;
    cfg_pin_en = 1'b1; cfg_pin_sel = 1'b0;
    edges(6);
    at_neg(); flag_clr = 2'b11;
    at_neg(); flag_clr = 2'b00;
    edges(1);
    check(rise_flag | fall_flag, 1'b0, "R9 cleared");
    at_neg(); raw_in = 1'b1;
    edges(2);
    check(cond_out, 1'b0, "R2 not before edge 3");
    edges(1);
    check(cond_out, 1'b1, "R2 after edge 3");
    check(rise_flag, 1'b0, "R9 flag one edge later");
    edges(1);
    check(rise_flag, 1'b1, "R9 rise set");
    check(pin_out, 1'b1, "R8 pin follows cond");

    // R10 routing
    at_neg(); cfg_rise_ie = 1'b1; cfg_fall_ie = 1'b0; cfg_dma_en = 1'b0;
    edges(1);
    check(irq, 1'b1, "R10 irq");
    check(dma_req, 1'b0, "R10 no dma");
    at_neg(); cfg_dma_en = 1'b1;
    edges(1);
    check(dma_req, 1'b1, "R10 dma");
    check(irq, 1'b0, "R10 no irq");
    at_neg(); flag_clr = 2'b01;
    at_neg(); flag_clr = 2'b00;
    edges(3);
    check(rise_flag, 1'b1 ^ 1'b1, "R9 rise cleared and sticky-off");
    check(dma_req, 1'b0, "R10 no request after clear");
    at_neg(); raw_in = 1'b0;
    edges(6);
    check(fall_flag, 1'b1, "R9 fall set");
    check(dma_req, 1'b0, "R10 fall not enabled");
    check(rise_flag, 1'b0, "R9 rise stays clear");

    // R8 pin gating and selection
    at_neg(); cfg_pin_en = 1'b0; raw_in = 1'b1;
    edges(6);
    check(pin_out, 1'b0, "R8 pin disabled");
    at_neg(); cfg_mode = 3'd3; win_in = 1'b0; raw_in = 1'b0; cfg_pin_en = 1'b1;
    edges(6);
    check(cond_out, 1'b1, "R6 held while closed");
    at_neg(); cfg_pin_sel = 1'b1;
    edges(2);
    check(pin_out, 1'b0, "R8 pin unconditioned");
    at_neg(); cfg_pin_sel = 1'b0;
    edges(2);
    check(pin_out, 1'b1, "R8 pin conditioned");

    // R5 short glitch rejected
    at_neg(); cfg_mode = 3'd2; cfg_ext_samp = 1'b0; cfg_filt_per = 8'd1; cfg_filt_cnt = 3'd3;
    raw_in = 1'b0;
    edges(10);
    check(cond_out, 1'b0, "R5 settle low");
    at_neg(); raw_in = 1'b1;
    at_neg();
    at_neg(); raw_in = 1'b0;
    edges(10);
    check(cond_out, 1'b0, "R5 glitch rejected");
    at_neg(); raw_in = 1'b1;
    edges(10);
    check(cond_out, 1'b1, "R5 long run accepted");

    // R5 latency window, period 4, count 2
    at_neg(); raw_in = 1'b0; cfg_filt_per = 8'd4; cfg_filt_cnt = 3'd2;
    edges(20);
    check(cond_out, 1'b0, "R5 settle");
    at_neg(); raw_in = 1'b1;
    edges(6);
    check(cond_out, 1'b0, "R5 not before 7 edges");
    edges(4);
    check(cond_out, 1'b1, "R5 by 10 edges");

    // R4 external sample edges
    at_neg(); cfg_mode = 3'd1; cfg_ext_samp = 1'b1; samp_in = 1'b0; raw_in = 1'b0;
    edges(20);
    check(cond_out, 1'b1, "R4 no strobe holds");
    at_neg(); samp_in = 1'b1;
    edges(5);
    check(cond_out, 1'b0, "R4 external strobe captures");
    at_neg(); raw_in = 1'b1;
    edges(10);
    check(cond_out, 1'b0, "R4 level high is not a strobe");
    at_neg(); samp_in = 1'b0;

    // R7 closed window freezes filtered output
    at_neg(); cfg_mode = 3'd4; cfg_ext_samp = 1'b0; cfg_filt_per = 8'd2; win_in = 1'b0;
    raw_in = 1'b1;
    edges(30);
    check(cond_out, 1'b0, "R7 closed window freeze");
    at_neg(); win_in = 1'b1;
    edges(30);
    check(cond_out, 1'b1, "R7 open window passes");

    finish_run();
  end
endmodule